// File: doc/BRIEF.md
# Daisy-Chained Vectored Interrupt Node

This block is one node on a bus where seven active-low request lines carry interrupt levels and a single acknowledge travels from node to node along a chain. A peripheral raises `periph_req`. The node latches that request and pulls down the one request line picked by its static level setting `cfg_level`. When the interrupt handler acknowledges, it places the level it is serving on `ack_lvl` and sends `iack_in_n` into the chain. Each node then takes one of two actions. It absorbs the acknowledge if it holds a pending request at exactly that level. Otherwise it passes the acknowledge on through `iack_out_n`.

An absorbing node withdraws its request and waits for the data strobe `ds_n`. The strobe may already be low, or it may arrive later. The node then drives the status/ID byte chosen by `cfg_vec_sel` and pulls `dtack_n` low. When the strobe rises, the node releases the data lines and `dtack_n`. It returns to idle once the acknowledge has gone away.

All bus inputs are synchronised with two flops. A controller built from five states decides the outcome once per clock: `ST_IDLE`, `ST_PASS`, `ST_GRAB`, `ST_DRIVE` and `ST_DONE`. A new request and an acknowledge may reach the controller in the same clock. In that case the acknowledge is passed on and the request stays pending.

The transitions are:
- `ST_IDLE` goes to `ST_GRAB` on an acknowledge when a request is pending and the levels match.
- `ST_IDLE` goes to `ST_PASS` on any other acknowledge.
- `ST_PASS` goes to `ST_IDLE` when the acknowledge is released.
- `ST_GRAB` goes to `ST_DRIVE` when the strobe is asserted.
- `ST_GRAB` goes to `ST_IDLE` if the acknowledge is withdrawn first.
- `ST_DRIVE` goes to `ST_DONE` when the strobe is released.
- `ST_DONE` goes to `ST_IDLE` when the acknowledge is released.

Top module: `irq_daisy_node`

## Requirements
- R1: After reset, all seven `irq_n` lines and both `iack_out_n` and `dtack_n` are high, `data_oe` is low and `data_out` is zero.
- R2: A rising edge of `periph_req` sets a pending flag. While it is pending, `irq_n[cfg_level-1]` is low and all other lines are high. At most one line is ever low. With `cfg_level` = 0 no line is driven.
- R3: The levels match only when the synchronised `ack_lvl` equals `cfg_level` and `cfg_level` is non-zero.
- R4: With nothing pending, `iack_out_n` falls on the third rising clock edge after `iack_in_n` falls. It rises on the third edge after `iack_in_n` rises.
- R5: With a request pending but no level match, the acknowledge is passed through in the same way as in R4.
- R6: With a request pending and a level match, the acknowledge is absorbed. `iack_out_n` stays high and the request line is released in the same cycle the decision is made.
- R7: While absorbing with the strobe low, the node drives `data_out` = 0x40 + 0x11 × `cfg_vec_sel` (8 bits) with `data_oe` high and `dtack_n` low. The byte is held steady for the whole transfer.
- R8: The strobe and the acknowledge are accepted in either order. Nothing is driven before both have been seen.
- R9: When the strobe rises, `data_oe` goes low and `dtack_n` high. A new falling edge of the strobe before the acknowledge is released drives nothing.
- R10: A request first seen in the same clock as the acknowledge counts as a tie. The acknowledge is passed on and the request stays pending for a later acknowledge. A request seen at least one clock earlier wins and is absorbed.
- R11: After service, a `periph_req` that is still held high does not raise a new request. The next acknowledge passes through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| periph_req | input | 1 | Peripheral request, active high, asynchronous |
| cfg_level | input | 3 | Static request level, 1 to 7 (0 = none) |
| cfg_vec_sel | input | 3 | Static status/ID byte selector |
| ack_lvl | input | 3 | Level being acknowledged, asynchronous |
| ds_n | input | 1 | Data strobe, active low, asynchronous |
| iack_in_n | input | 1 | Incoming chain acknowledge, active low |
| irq_n | output | 7 | Request lines, bit k = level k+1, active low |
| iack_out_n | output | 1 | Outgoing chain acknowledge, active low |
| data_out | output | 8 | Status/ID byte, zero when not driven |
| data_oe | output | 1 | Data bus output enable |
| dtack_n | output | 1 | Data acknowledge, active low |

## Verification
Every input edge reaches the controller on the third rising clock edge, because it passes two synchroniser flops and then the state register. Request lines and pass-through therefore change after three edges. The byte and `dtack_n` need a fourth edge when the strobe is already low at the moment the acknowledge is taken. The bench samples on falling edges and usually waits five edges after each stimulus, so results are never read while they are still in flight. The R4 test is the exception: it samples at the second and third edges to show the exact latency. The race test uses the same sampling in two setups. In one, request and acknowledge are driven on the same falling edge. In the other, they are driven one clock apart.

// File: rtl/irqd_pkg.sv
package irqd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PASS,
        ST_GRAB,
        ST_DRIVE,
        ST_DONE
    } irqd_state_e;
endpackage

// File: rtl/irqd_sync.sv
module irqd_sync #(
    parameter int          W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/irqd_vec_rom.sv
module irqd_vec_rom #(
    parameter int SEL_W = 3,
    parameter int DW    = 8,
    parameter int BASE  = 8'h40,
    parameter int STEP  = 8'h11
) (
    input  logic [SEL_W-1:0] sel,
    output logic [DW-1:0]    vec
);
    localparam int N = 1 << SEL_W;

    logic [DW-1:0] tbl [N];

    for (genvar i = 0; i < N; i++) begin : g_entry
        assign tbl[i] = DW'(BASE + i * STEP);
    end

    assign vec = tbl[sel];
endmodule

// File: rtl/irqd_ctrl.sv
module irqd_ctrl
    import irqd_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic ack_seen,
    input  logic strobe_seen,
    input  logic pend,
    input  logic match,
    output logic take,
    output logic pass_on,
    output logic drive
);
    irqd_state_e state, nxt;

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:  if (ack_seen) nxt = (pend && match) ? ST_GRAB : ST_PASS;
            ST_PASS:  if (!ack_seen) nxt = ST_IDLE;
            ST_GRAB: begin
                if (strobe_seen)   nxt = ST_DRIVE;
                else if (!ack_seen) nxt = ST_IDLE;
            end
            ST_DRIVE: if (!strobe_seen) nxt = ST_DONE;
            ST_DONE:  if (!ack_seen) nxt = ST_IDLE;
            default:  nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        take    = (state == ST_IDLE) && ack_seen && pend && match;
        pass_on = (state == ST_PASS);
        drive   = (state == ST_DRIVE);
    end
endmodule

// File: rtl/irq_daisy_node.sv
module irq_daisy_node #(
    parameter int LVL_W    = 3,
    parameter int SEL_W    = 3,
    parameter int DW       = 8,
    parameter int VEC_BASE = 8'h40,
    parameter int VEC_STEP = 8'h11
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          periph_req,
    input  logic [LVL_W-1:0]              cfg_level,
    input  logic [SEL_W-1:0]              cfg_vec_sel,
    input  logic [LVL_W-1:0]              ack_lvl,
    input  logic                          ds_n,
    input  logic                          iack_in_n,
    output logic [(1<<LVL_W)-2:0]         irq_n,
    output logic                          iack_out_n,
    output logic [DW-1:0]                 data_out,
    output logic                          data_oe,
    output logic                          dtack_n
);
    localparam int NLVL = (1 << LVL_W) - 1;
    localparam int SW   = LVL_W + 3;
    localparam logic [SW-1:0] SYNC_RST = {1'b0, 1'b1, 1'b1, {LVL_W{1'b0}}};

    logic [SW-1:0]    sync_q;
    logic             req_s, ds_s_n, iack_s_n;
    logic [LVL_W-1:0] ack_s;
    logic             req_q, pend, match;
    logic             take, pass_on, drive;
    logic [DW-1:0]    vec;

    irqd_sync #(.W(SW), .RST_VAL(SYNC_RST)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({periph_req, ds_n, iack_in_n, ack_lvl}),
        .q     (sync_q)
    );

    assign {req_s, ds_s_n, iack_s_n, ack_s} = sync_q;

    // request latch: set on a new request edge, cleared when the acknowledge is taken
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= 1'b0;
            pend  <= 1'b0;
        end else begin
            req_q <= req_s;
            if (take)                pend <= 1'b0;
            else if (req_s && !req_q) pend <= 1'b1;
        end
    end

    assign match = (cfg_level != '0) && (ack_s == cfg_level);

    irqd_vec_rom #(.SEL_W(SEL_W), .DW(DW), .BASE(VEC_BASE), .STEP(VEC_STEP)) u_rom (
        .sel (cfg_vec_sel),
        .vec (vec)
    );

    irqd_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .ack_seen    (!iack_s_n),
        .strobe_seen (!ds_s_n),
        .pend        (pend),
        .match       (match),
        .take        (take),
        .pass_on     (pass_on),
        .drive       (drive)
    );

    for (genvar k = 0; k < NLVL; k++) begin : g_line
        assign irq_n[k] = !(pend && (cfg_level == LVL_W'(k + 1)));
    end

    always_comb begin
        iack_out_n = !pass_on;
        data_oe    = drive;
        dtack_n    = !drive;
        data_out   = drive ? vec : '0;
    end
endmodule

// File: rtl/irqd_checker.sv
module irqd_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       ds_n,
    input logic       iack_in_n,
    input logic [6:0] irq_n,
    input logic       iack_out_n,
    input logic [7:0] data_out,
    input logic       data_oe,
    input logic       dtack_n
);
    a_r2_one_line: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~irq_n) <= 1);

    a_r4_pass_follows_ack: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(iack_out_n) |-> !$past(iack_in_n, 2));

    a_r6_no_pass_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
        data_oe |-> iack_out_n);

    a_r7_byte_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (data_oe && $past(data_oe)) |-> $stable(data_out));

    a_r8_drive_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dtack_n) |-> !$past(ds_n, 2));

    a_r9_release_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dtack_n) |-> $past(ds_n, 2));
endmodule

bind irq_daisy_node irqd_checker u_chk (.*);

// File: tb/irq_daisy_node_test.sv
module irq_daisy_node_test;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       periph_req;
    logic [2:0] cfg_level, cfg_vec_sel, ack_lvl;
    logic       ds_n, iack_in_n;
    logic [6:0] irq_n;
    logic       iack_out_n;
    logic [7:0] data_out;
    logic       data_oe, dtack_n;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    irq_daisy_node uut (
        .clk(clk), .rst_n(rst_n), .periph_req(periph_req),
        .cfg_level(cfg_level), .cfg_vec_sel(cfg_vec_sel), .ack_lvl(ack_lvl),
        .ds_n(ds_n), .iack_in_n(iack_in_n), .irq_n(irq_n),
        .iack_out_n(iack_out_n), .data_out(data_out), .data_oe(data_oe),
        .dtack_n(dtack_n)
    );

    // fields: [10:8] level, [7:5] ack level, [4] request, [3:1] selector, [0] absorb expected
    localparam logic [10:0] VEC [8] = '{
        {3'd3, 3'd3, 1'b1, 3'd2, 1'b1},
        {3'd3, 3'd5, 1'b1, 3'd2, 1'b0},
        {3'd5, 3'd5, 1'b0, 3'd1, 1'b0},
        {3'd7, 3'd7, 1'b1, 3'd7, 1'b1},
        {3'd1, 3'd1, 1'b1, 3'd0, 1'b1},
        {3'd2, 3'd3, 1'b1, 3'd4, 1'b0},
        {3'd6, 3'd6, 1'b1, 3'd5, 1'b1},
        {3'd4, 3'd4, 1'b0, 3'd3, 1'b0}
    };

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] byte_of(input logic [2:0] s);
        return 8'(8'h40 + 8'h11 * s);
    endfunction

    function automatic logic [6:0] line_of(input logic [2:0] l);
        return (l == 0) ? 7'h7F : ~(7'd1 << (l - 1));
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        periph_req = 1'b0; ds_n = 1'b1; iack_in_n = 1'b1;
        ack_lvl = 3'd0;
        tick(2);
        rst_n = 1'b1;
        tick(1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        cfg_level = 3'd0; cfg_vec_sel = 3'd0;
        do_reset();
        // R1 reset state
        chk("R1 irq_n", irq_n, 7'h7F);
        chk("R1 iack_out_n", iack_out_n, 1'b1);
        chk("R1 dtack_n", dtack_n, 1'b1);
        chk("R1 data_oe", data_oe, 1'b0);
        chk("R1 data_out", data_out, 8'h00);

        // table walk
        for (int i = 0; i < 8; i++) begin
            logic [10:0] v;
            v = VEC[i];
            do_reset();
            cfg_level = v[10:8]; ack_lvl = v[7:5]; cfg_vec_sel = v[3:1];
            periph_req = v[4];
            tick(5);
            chk("R2 line", irq_n, v[4] ? line_of(v[10:8]) : 7'h7F);
            iack_in_n = 1'b0; ds_n = 1'b0;
            tick(5);
            if (v[0]) begin
                chk("R6 absorb keeps chain", iack_out_n, 1'b1);
                chk("R6 request withdrawn", irq_n, 7'h7F);
                chk("R7 byte", data_out, byte_of(v[3:1]));
                chk("R7 oe", data_oe, 1'b1);
                chk("R7 dtack", dtack_n, 1'b0);
            end else begin
                chk(v[4] ? "R5 pass mismatch" : "R4 pass idle", iack_out_n, 1'b0);
                chk("R3 no drive", dtack_n, 1'b1);
                chk("R3 no oe", data_oe, 1'b0);
            end
            ds_n = 1'b1; iack_in_n = 1'b1;
            tick(5);
            chk("R9 released dtack", dtack_n, 1'b1);
            chk("R9 released oe", data_oe, 1'b0);
            chk("R4 chain idle", iack_out_n, 1'b1);
        end

        // R2 / R3: level 0 drives nothing and never matches
        do_reset();
        cfg_level = 3'd0; ack_lvl = 3'd0; periph_req = 1'b1;
        tick(5);
        chk("R2 level zero", irq_n, 7'h7F);
        iack_in_n = 1'b0; ds_n = 1'b0;
        tick(5);
        chk("R3 zero level passes", iack_out_n, 1'b0);
        chk("R3 zero level no drive", data_oe, 1'b0);
        iack_in_n = 1'b1; ds_n = 1'b1;
        tick(5);

        // R4 exact latency
        do_reset();
        cfg_level = 3'd2;
        iack_in_n = 1'b0;
        tick(2);
        chk("R4 not yet at edge 2", iack_out_n, 1'b1);
        tick(1);
        chk("R4 passed at edge 3", iack_out_n, 1'b0);
        iack_in_n = 1'b1;
        tick(2);
        chk("R4 held at edge 2", iack_out_n, 1'b0);
        tick(1);
        chk("R4 released at edge 3", iack_out_n, 1'b1);

        // R10 tie: request and acknowledge in the same cycle
        do_reset();
        cfg_level = 3'd4; ack_lvl = 3'd4; cfg_vec_sel = 3'd3;
        periph_req = 1'b1; iack_in_n = 1'b0; ds_n = 1'b0;
        tick(5);
        chk("R10 tie passes", iack_out_n, 1'b0);
        chk("R10 tie no dtack", dtack_n, 1'b1);
        chk("R10 tie request kept", irq_n, line_of(3'd4));
        iack_in_n = 1'b1; ds_n = 1'b1;
        tick(5);
        iack_in_n = 1'b0; ds_n = 1'b0;
        tick(5);
        chk("R10 later absorb", data_out, byte_of(3'd3));
        iack_in_n = 1'b1; ds_n = 1'b1;
        tick(5);

        // R10 request one clock earlier wins; then R9 and R11
        do_reset();
        cfg_level = 3'd2; ack_lvl = 3'd2; cfg_vec_sel = 3'd0;
        periph_req = 1'b1;
        tick(1);
        iack_in_n = 1'b0; ds_n = 1'b0;
        tick(5);
        chk("R10 request wins oe", data_oe, 1'b1);
        chk("R10 request wins chain", iack_out_n, 1'b1);
        ds_n = 1'b1;
        tick(5);
        chk("R9 strobe up dtack", dtack_n, 1'b1);
        chk("R9 strobe up oe", data_oe, 1'b0);
        ds_n = 1'b0;
        tick(5);
        chk("R9 second strobe ignored", data_oe, 1'b0);
        chk("R9 second strobe chain", iack_out_n, 1'b1);
        ds_n = 1'b1; iack_in_n = 1'b1;
        tick(5);
        chk("R11 held request not relatched", irq_n, 7'h7F);
        iack_in_n = 1'b0;
        tick(5);
        chk("R11 next ack passes", iack_out_n, 1'b0);
        iack_in_n = 1'b1;
        tick(5);

        // R8 strobe before acknowledge
        do_reset();
        cfg_level = 3'd5; ack_lvl = 3'd5; cfg_vec_sel = 3'd6; periph_req = 1'b1;
        tick(5);
        ds_n = 1'b0;
        tick(5);
        chk("R8 strobe alone no drive", dtack_n, 1'b1);
        iack_in_n = 1'b0;
        tick(5);
        chk("R8 strobe first byte", data_out, byte_of(3'd6));
        chk("R8 strobe first dtack", dtack_n, 1'b0);
        ds_n = 1'b1; iack_in_n = 1'b1;
        tick(5);

        // R8 acknowledge before strobe
        do_reset();
        cfg_level = 3'd3; ack_lvl = 3'd3; cfg_vec_sel = 3'd1; periph_req = 1'b1;
        tick(5);
        iack_in_n = 1'b0;
        tick(5);
        chk("R8 ack alone no drive", data_oe, 1'b0);
        chk("R6 withdrawn before strobe", irq_n, 7'h7F);
        chk("R6 absorbed chain", iack_out_n, 1'b1);
        ds_n = 1'b0;
        tick(5);
        chk("R8 ack first byte", data_out, byte_of(3'd1));
        chk("R8 ack first dtack", dtack_n, 1'b0);
        ds_n = 1'b1; iack_in_n = 1'b1;
        tick(5);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule